// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Loader

This block loads a serial configuration chain from data that software stages in shared memory. The shared region holds two equal blocks of configuration data, and the two are used in turn: while the hardware consumes one, software refills the other. The block stays idle until software sends a "block ready" message. It then copies the whole block, one word at a time, over a simple read port into a local on-chip buffer. After that it streams the buffer into the chain, one bit per clock with an enable, and finally sends a message asking software for the next block.

A block is 8 KiB by default. That is 2048 words of 32 bits, read at ascending addresses. Each word leaves the block most significant bit first. The "block ready" message carries a flag that marks the final block of a stream. On that block the loader sends no request at the end. It signals completion with a one-cycle pulse instead, and the next stream starts again at the first half of the region. Bit order, word width, block size and region base are parameters.

Top module: `cfg_block_loader`

## Requirements
- R1: After reset, `msg_in_ready` is 1 and `cfg_en`, `mem_req_valid`, `msg_out_valid` and `done` are all 0.
- R2: A "block ready" message (`msg_in_valid` high while `msg_in_ready` is high) is accepted only when the loader is idle. `msg_in_ready` is 0 from the cycle after acceptance until the loader is idle again. A message offered while busy, including its last-block flag, has no effect on the block in progress.
- R3: After a message is accepted, every word of one block is read in ascending order. Word i is read at address `REGION_BASE + h*BLOCK_BYTES + i*(DATA_W/8)`, where h (0 or 1) selects the half. Every address is word aligned.
- R4: A read request holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is high. At most one read is outstanding, and the next request waits for `mem_rsp_valid`.
- R5: The first `cfg_en` cycle comes 2 cycles after the cycle of the block's final read response. `cfg_en` then stays high for exactly WORDS*DATA_W consecutive cycles. `cfg_bit` carries the words in read order, each most significant bit first.
- R6: No read request is issued while `cfg_en` is high; shifting runs entirely from the local buffer.
- R7: For a block without the last-block flag, `msg_out_valid` rises in the cycle right after the final shifted bit. It is held until `msg_out_ready` is seen, and the loader is then idle.
- R8: Consecutive blocks alternate halves: h starts at 0 and flips after each block has been shifted out.
- R9: For a block carrying the last-block flag, `done` is high for exactly one cycle, the cycle after the final shifted bit. No `msg_out_valid` is raised, the loader returns to idle, and the next block is read from half 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_in_valid | input | 1 | Software message "block ready" is offered |
| msg_in_last | input | 1 | The offered block is the final one of the stream |
| msg_in_ready | output | 1 | Loader is idle and takes the message |
| msg_out_valid | output | 1 | Request to software for the next block |
| msg_out_ready | input | 1 | Software takes the request |
| mem_req_valid | output | 1 | Read request is valid |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | ADDR_W | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is valid (one cycle per request) |
| mem_rsp_data | input | DATA_W | Read data |
| cfg_en | output | 1 | Configuration chain shift enable |
| cfg_bit | output | 1 | Serial configuration data |
| done | output | 1 | One-cycle pulse after the final block of a stream |

## Verification
Every result has a fixed cycle position relative to its stimulus. A read request is issued in the cycle after the message is taken, or after the previous response. The first shift cycle is two cycles after the final response. `done` or `msg_out_valid` appears in the cycle after the final bit, and `msg_out_valid` clears in the cycle after `msg_out_ready`. The bench records cycle numbers for the final response and for the first and last enabled bit, then compares their differences with those values. Status outputs are sampled at the falling edge, after the settle delay that follows the edge at which each output is due. The bench also drives stalled ready patterns and several response latencies, which move the absolute cycles while the relative offsets stay fixed.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ   = 3'd1,
      ST_WAIT  = 3'd2,
      ST_LOAD  = 3'd3,
      ST_SHIFT = 3'd4,
      ST_ASK   = 3'd5
   } seq_state_t;

endpackage

// File: rtl/cfgl_lbuf.sv
module cfgl_lbuf #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 2048,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_idx] <= wr_data;
   end

   assign rd_data = store[rd_idx];

endmodule

// File: rtl/cfgl_serializer.sv
module cfgl_serializer #(
   parameter int DATA_W    = 32,
   parameter int DEPTH     = 2048,
   parameter bit MSB_FIRST = 1'b1,
   localparam int IDX_W    = $clog2(DEPTH),
   localparam int BIT_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [DATA_W-1:0] rd_data,
   output logic              cfg_en,
   output logic              cfg_bit,
   output logic              fin
);

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shreg_next;
   logic [BIT_W-1:0]  bit_cnt;
   logic [IDX_W-1:0]  word_ptr;
   logic              active;
   logic              cur_last;
   logic              word_end;

   generate
      if (MSB_FIRST) begin : g_msb
         assign cfg_bit    = shreg[DATA_W-1];
         assign shreg_next = {shreg[DATA_W-2:0], 1'b0};
      end else begin : g_lsb
         assign cfg_bit    = shreg[0];
         assign shreg_next = {1'b0, shreg[DATA_W-1:1]};
      end
   endgenerate

   assign word_end = (bit_cnt == BIT_W'(DATA_W - 1));
   assign rd_idx   = start ? '0 : word_ptr;
   assign cfg_en   = active;
   assign fin      = active && word_end && cur_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg    <= '0;
         bit_cnt  <= '0;
         word_ptr <= '0;
         active   <= 1'b0;
         cur_last <= 1'b0;
      end else if (start) begin
         shreg    <= rd_data;
         bit_cnt  <= '0;
         word_ptr <= IDX_W'(1);
         active   <= 1'b1;
         cur_last <= 1'b0;
      end else if (active) begin
         if (word_end) begin
            bit_cnt <= '0;
            if (cur_last) begin
               active <= 1'b0;
               shreg  <= '0;
            end else begin
               shreg    <= rd_data;
               cur_last <= (word_ptr == IDX_W'(DEPTH - 1));
               word_ptr <= word_ptr + 1'b1;
            end
         end else begin
            shreg   <= shreg_next;
            bit_cnt <= bit_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
   import cfgl_pkg::*;
#(
   parameter int              ADDR_W      = 32,
   parameter int              DEPTH       = 2048,
   parameter int              WORD_BYTES  = 4,
   parameter logic [ADDR_W-1:0] REGION_BASE = '0,
   localparam int             IDX_W       = $clog2(DEPTH),
   localparam int             WORD_SH     = $clog2(WORD_BYTES),
   localparam logic [ADDR_W-1:0] HALF_OFS = ADDR_W'(DEPTH * WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_in_valid,
   input  logic              msg_in_last,
   output logic              msg_in_ready,
   output logic              msg_out_valid,
   input  logic              msg_out_ready,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              shift_start,
   input  logic              shift_fin,
   output logic              done
);

   seq_state_t       state;
   logic [IDX_W-1:0] cp_idx;
   logic             half_q;
   logic             last_q;
   logic             done_q;

   assign msg_in_ready  = (state == ST_IDLE);
   assign mem_req_valid = (state == ST_REQ);
   assign msg_out_valid = (state == ST_ASK);
   assign shift_start   = (state == ST_LOAD);
   assign wr_en         = (state == ST_WAIT) && mem_rsp_valid;
   assign wr_idx        = cp_idx;
   assign done          = done_q;
   assign mem_req_addr  = REGION_BASE + (half_q ? HALF_OFS : '0)
                        + (ADDR_W'(cp_idx) << WORD_SH);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cp_idx <= '0;
         half_q <= 1'b0;
         last_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (msg_in_valid) begin
                  last_q <= msg_in_last;
                  cp_idx <= '0;
                  state  <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (mem_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (cp_idx == IDX_W'(DEPTH - 1)) begin
                     state <= ST_LOAD;
                  end else begin
                     cp_idx <= cp_idx + 1'b1;
                     state  <= ST_REQ;
                  end
               end
            end
            ST_LOAD: state <= ST_SHIFT;
            ST_SHIFT: begin
               if (shift_fin) begin
                  if (last_q) begin
                     half_q <= 1'b0;
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else begin
                     half_q <= ~half_q;
                     state  <= ST_ASK;
                  end
               end
            end
            ST_ASK: begin
               if (msg_out_ready) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfg_block_loader.sv
module cfg_block_loader #(
   parameter int                ADDR_W      = 32,
   parameter int                DATA_W      = 32,
   parameter int                BLOCK_BYTES = 8192,
   parameter logic [ADDR_W-1:0] REGION_BASE = '0,
   parameter bit                MSB_FIRST   = 1'b1,
   localparam int               WORD_BYTES  = DATA_W / 8,
   localparam int               DEPTH       = BLOCK_BYTES / WORD_BYTES,
   localparam int               IDX_W       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_in_valid,
   input  logic              msg_in_last,
   output logic              msg_in_ready,
   output logic              msg_out_valid,
   input  logic              msg_out_ready,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              cfg_en,
   output logic              cfg_bit,
   output logic              done
);

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a positive multiple of 8");
      end
      if ((BLOCK_BYTES % WORD_BYTES) != 0) begin : g_bad_block
         $error("BLOCK_BYTES must hold a whole number of words");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("words per block must be a power of two, at least 2");
      end
      if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_pow
         $error("DATA_W must be a power of two");
      end
      if ((REGION_BASE % ADDR_W'(BLOCK_BYTES)) != '0) begin : g_bad_base
         $error("REGION_BASE must be aligned to BLOCK_BYTES");
      end
   endgenerate

   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;
   logic [DATA_W-1:0] rd_data;
   logic             shift_start;
   logic             shift_fin;

   cfgl_seq #(
      .ADDR_W      (ADDR_W),
      .DEPTH       (DEPTH),
      .WORD_BYTES  (WORD_BYTES),
      .REGION_BASE (REGION_BASE)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .msg_in_valid  (msg_in_valid),
      .msg_in_last   (msg_in_last),
      .msg_in_ready  (msg_in_ready),
      .msg_out_valid (msg_out_valid),
      .msg_out_ready (msg_out_ready),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .wr_en         (wr_en),
      .wr_idx        (wr_idx),
      .shift_start   (shift_start),
      .shift_fin     (shift_fin),
      .done          (done)
   );

   cfgl_lbuf #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_lbuf (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (mem_rsp_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data)
   );

   cfgl_serializer #(
      .DATA_W    (DATA_W),
      .DEPTH     (DEPTH),
      .MSB_FIRST (MSB_FIRST)
   ) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (shift_start),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .cfg_en  (cfg_en),
      .cfg_bit (cfg_bit),
      .fin     (shift_fin)
   );

endmodule

// File: rtl/cfg_block_loader_chk.sv
module cfg_block_loader_chk #(
   parameter int ADDR_W  = 32,
   parameter int WORD_SH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              msg_in_ready,
   input logic              msg_out_valid,
   input logic              msg_out_ready,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              cfg_en,
   input logic              done
);

   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << WORD_SH) - 1);

   // R2
   idle_only_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en || mem_req_valid || msg_out_valid) |-> !msg_in_ready);

   // R3
   aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> ((mem_req_addr & LOW_MASK) == '0));

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R6
   no_fetch_while_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |-> !mem_req_valid);

   // R7
   ask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_out_valid && !msg_out_ready) |=> msg_out_valid);

   // R7
   shift_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfg_en) |-> (done || msg_out_valid));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_no_ask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!msg_out_valid && !cfg_en));

endmodule

bind cfg_block_loader cfg_block_loader_chk #(
   .ADDR_W  (ADDR_W),
   .WORD_SH ($clog2(DATA_W / 8))
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .msg_in_ready  (msg_in_ready),
   .msg_out_valid (msg_out_valid),
   .msg_out_ready (msg_out_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .cfg_en        (cfg_en),
   .done          (done)
);

// File: tb/cfg_block_loader_test.sv
`timescale 1ns/1ps
module cfg_block_loader_test;

   localparam int          BYTES = 32;
   localparam int          WORDS = BYTES / 4;
   localparam int          NBITS = WORDS * 32;
   localparam logic [31:0] BASE  = 32'h0000_4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_in_valid = 1'b0;
   logic        msg_in_last = 1'b0;
   logic        msg_in_ready;
   logic        msg_out_valid;
   logic        msg_out_ready = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        cfg_en;
   logic        cfg_bit;
   logic        done;

   int checks = 0;
   int errs   = 0;
   int cyc    = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   cfg_block_loader #(
      .ADDR_W      (32),
      .DATA_W      (32),
      .BLOCK_BYTES (BYTES),
      .REGION_BASE (BASE)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .msg_in_valid  (msg_in_valid),
      .msg_in_last   (msg_in_last),
      .msg_in_ready  (msg_in_ready),
      .msg_out_valid (msg_out_valid),
      .msg_out_ready (msg_out_ready),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .cfg_en        (cfg_en),
      .cfg_bit       (cfg_bit),
      .done          (done)
   );

   function automatic logic [31:0] fill(input logic [31:0] a, input logic [31:0] g);
      return (a * 32'h9E37_79B9) ^ g ^ {a[15:0], ~a[15:0]};
   endfunction

   // memory model
   logic [31:0] gen = 32'h0;
   bit          rdy_mode = 1'b0;
   int          lat_cfg = 1;
   int          rcnt;
   logic [31:0] rsp_buf;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_req_ready <= 1'b1;
         rcnt          <= 0;
         mem_rsp_valid <= 1'b0;
         mem_rsp_data  <= '0;
         rsp_buf       <= '0;
      end else begin
         mem_req_ready <= rdy_mode ? ~mem_req_ready : 1'b1;
         if (mem_req_valid && mem_req_ready) begin
            rcnt          <= lat_cfg;
            rsp_buf       <= fill(mem_req_addr, gen);
            mem_rsp_valid <= 1'b0;
         end else if (rcnt != 0) begin
            rcnt          <= rcnt - 1;
            mem_rsp_valid <= (rcnt == 1);
            mem_rsp_data  <= (rcnt == 1) ? rsp_buf : 32'h0;
         end else begin
            mem_rsp_valid <= 1'b0;
         end
      end
   end

   // monitor (falling edge)
   logic [31:0] addr_log [WORDS];
   logic        bit_log  [NBITS];
   int  acnt, bcnt, first_en, last_en, last_rsp;
   int  hold_viol, outst_viol, ovl_viol;
   bit  prev_stall;
   logic [31:0] prev_addr;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall && !(mem_req_valid && mem_req_addr == prev_addr)) hold_viol++;
         prev_stall = mem_req_valid && !mem_req_ready;
         prev_addr  = mem_req_addr;
         if (mem_req_valid && mem_req_ready) begin
            if (rcnt != 0 || mem_rsp_valid) outst_viol++;
            if (acnt < WORDS) addr_log[acnt] = mem_req_addr;
            acnt++;
         end
         if (mem_req_valid && cfg_en) ovl_viol++;
         if (mem_rsp_valid) last_rsp = cyc;
         if (cfg_en) begin
            if (bcnt == 0) first_en = cyc;
            last_en = cyc;
            if (bcnt < NBITS) bit_log[bcnt] = cfg_bit;
            bcnt++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) step();
      check(msg_in_ready == 1'b1 && !cfg_en && !mem_req_valid && !msg_out_valid && !done,
            "R1", "outputs in reset",
            {27'd0, msg_in_ready, cfg_en, mem_req_valid, msg_out_valid, done}, 32'h10);
      rst_n = 1'b1;
      step();
      check(msg_in_ready == 1'b1 && !cfg_en && !mem_req_valid && !msg_out_valid && !done,
            "R1", "outputs after reset",
            {27'd0, msg_in_ready, cfg_en, mem_req_valid, msg_out_valid, done}, 32'h10);
   endtask

   task automatic run_block(input bit last, input logic [31:0] g, input bit half,
                            input int ask_delay, input bit poke, input bit rdy_t,
                            input int lat);
      int n;
      int end_cyc;
      int bad;
      int first_bad;
      logic [31:0] exp_addr;
      gen = g; rdy_mode = rdy_t; lat_cfg = lat;
      acnt = 0; bcnt = 0; hold_viol = 0; outst_viol = 0; ovl_viol = 0;
      first_en = -1; last_en = -1; last_rsp = -1; prev_stall = 1'b0;
      check(msg_in_ready == 1'b1, "R2", "ready while idle", {31'd0, msg_in_ready}, 32'd1);
      msg_in_valid = 1'b1; msg_in_last = last;
      @(negedge clk);
      msg_in_valid = 1'b0; msg_in_last = 1'b0;
      #1;
      check(msg_in_ready == 1'b0, "R2", "ready after accept", {31'd0, msg_in_ready}, 32'd0);
      if (poke) begin
         n = 0;
         while (!cfg_en && n < 2000) begin step(); n++; end
         msg_in_valid = 1'b1; msg_in_last = 1'b1;
         check(msg_in_ready == 1'b0, "R2", "ready while shifting", {31'd0, msg_in_ready}, 32'd0);
         step();
         msg_in_valid = 1'b0; msg_in_last = 1'b0;
      end
      n = 0;
      while (!(msg_out_valid || done) && n < 5000) begin step(); n++; end
      end_cyc = cyc;
      check(acnt == WORDS, "R3", "read count", acnt, WORDS);
      bad = 0; first_bad = -1;
      for (int i = 0; i < WORDS; i++) begin
         exp_addr = BASE + (half ? BYTES : 0) + 4 * i;
         if (addr_log[i] !== exp_addr) begin bad++; if (first_bad < 0) first_bad = i; end
      end
      exp_addr = BASE + (half ? BYTES : 0) + 4 * (first_bad < 0 ? 0 : first_bad);
      check(bad == 0, "R8", "read addresses in half",
            addr_log[first_bad < 0 ? 0 : first_bad], exp_addr);
      check(hold_viol == 0, "R4", "request held while stalled", hold_viol, 0);
      check(outst_viol == 0, "R4", "single outstanding read", outst_viol, 0);
      check(ovl_viol == 0, "R6", "no read while shifting", ovl_viol, 0);
      check(bcnt == NBITS, "R5", "enabled bit count", bcnt, NBITS);
      check(last_en - first_en + 1 == NBITS, "R5", "gapless shift span",
            last_en - first_en + 1, NBITS);
      check(first_en - last_rsp == 2, "R5", "shift start latency", first_en - last_rsp, 2);
      bad = 0;
      for (int j = 0; j < NBITS; j++) begin
         exp_addr = BASE + (half ? BYTES : 0) + 4 * (j / 32);
         if (bit_log[j] !== fill(exp_addr, g)[31 - (j % 32)]) bad++;
      end
      check(bad == 0, "R5", "serial data MSB first", bad, 0);
      if (!last) begin
         check(msg_out_valid && !done && end_cyc == last_en + 1, "R7", "next-block request timing",
               end_cyc - last_en, 1);
         for (int k = 0; k < ask_delay; k++) step();
         check(msg_out_valid == 1'b1, "R7", "request held", {31'd0, msg_out_valid}, 32'd1);
         msg_out_ready = 1'b1;
         @(negedge clk);
         msg_out_ready = 1'b0;
         #1;
         check(!msg_out_valid && msg_in_ready, "R7", "idle after request taken",
               {30'd0, msg_out_valid, msg_in_ready}, 32'd1);
      end else begin
         check(done && !msg_out_valid && end_cyc == last_en + 1, "R9", "done pulse timing",
               end_cyc - last_en, 1);
         step();
         check(!done && !msg_out_valid && msg_in_ready, "R9", "single done pulse, idle",
               {29'd0, done, msg_out_valid, msg_in_ready}, 32'd1);
      end
   endtask

   task automatic test_first_block();
      run_block(1'b0, 32'h1111_0000, 1'b0, 3, 1'b0, 1'b0, 1);
   endtask

   task automatic test_stalled_block_with_poke();   // R2 ignored message, R4 stalls
      run_block(1'b0, 32'hA5A5_0F0F, 1'b1, 0, 1'b1, 1'b1, 3);
   endtask

   task automatic test_third_block();                // R8 wraps to half 0
      run_block(1'b0, 32'h0000_FFFF, 1'b0, 1, 1'b0, 1'b0, 2);
   endtask

   task automatic test_last_block();                 // R9
      run_block(1'b1, 32'h5A5A_C3C3, 1'b1, 0, 1'b0, 1'b1, 1);
   endtask

   task automatic test_restart_after_last();         // R9 next stream at half 0
      run_block(1'b0, 32'hDEAD_0001, 1'b0, 2, 1'b0, 1'b0, 4);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
      finish_run();
   end

   initial begin
      test_reset();
      test_first_block();
      test_stalled_block_with_poke();
      test_third_block();
      test_last_block();
      test_restart_after_last();
      repeat (3) step();
      finish_run();
   end

endmodule